// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block switches byte-wide channels between serial time-division-multiplexed lines. A frame pulse marks the first bit of channel 0. Every byte that arrives on an input line is stored in a banked data memory. Each output channel then takes its byte from a connection memory entry. That entry either names any stored input channel or holds a literal byte of its own. The entry also decides whether the channel is driven, forced high or left in high impedance.

Two line modes share the same capacity:
- **Slow mode:** all `NS` lines carry `CHS` channels each, and each bit lasts two clocks.
- **Fast mode:** the lower `NS/2` lines carry `2*CHS` channels each, and each bit lasts one clock.

A frame is always `16*CHS` clocks long. The serial lines run at a fixed rate and carry no back-pressure.

The connection memory is written through a valid/ready request port. A request is taken on a cycle where both `cm_wr_valid` and `cm_wr_ready` are high. The requester must hold its valid, address, data and fill signals stable until that cycle. The only back-pressure comes from a block fill, which keeps `cm_wr_ready` low for one whole frame.

Top module: `tdm_slot_switch`

## Requirements
- R1: Line timing.
  - The cycle in which `frame_pulse` is high is frame position 0. Each frame has `16*CHS` positions.
  - In slow mode, bit `i` of a frame occupies positions `2i` and `2i+1`. In fast mode, bit `i` occupies position `i`.
  - Bit `i` belongs to channel `i/8`. Bytes travel MSB first.
  - Inputs are sampled at the last position of each bit. Each output bit appears on the pins one clock after its frame position.
- R2: Channel addressing.
  - Every channel has a flat address: line × channels-per-line + channel, using the channels-per-line of the current mode.
  - In fast mode, input lines `NS/2` and above are ignored, and output lines `NS/2` and above stay in high impedance.
- R3: Switching and delay.
  - A switched output channel in frame G carries the byte received in frame G-2 at the source address.
  - Any source may feed any number of output channels.
- R4: Entry format and high impedance.
  - A connection entry is 11 bits: bit 10 enable, bit 9 force-high, bit 8 message, bits 7:0 source.
  - The source address is the low log2(`NS*CHS`) bits of the source field.
  - When the enable bit is 0, the channel is in high impedance (`ser_oe`=0, `ser_out`=0) whatever the other bits hold.
- R5: An enabled entry with force-high set drives 1 for the whole slot.
- R6: An enabled entry with message set and force-high clear outputs bits 7:0 of the entry, MSB first.
- R7: A single write (`cm_wr_fill`=0) that is taken stores `cm_wr_data` at `cm_wr_addr`. It governs that channel from the next clock.
- R8: Block fill.
  - A request that is taken with `cm_wr_fill`=1 ignores `cm_wr_addr`. It writes `cm_wr_data` to entry i on the i-th clock after it is taken.
  - It holds `cm_wr_ready` low for exactly `16*CHS` clocks.
- R9: Mode changes and start-up.
  - `mode_fast` is sampled only at frame start.
  - All outputs stay in high impedance during the first two frames after the first frame pulse, and during the frame of a mode change and the frame after it.
- R10: After reset, all `ser_oe` and `ser_out` bits are 0, `cm_wr_ready` is 1, and every connection entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one fast-mode bit time |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_pulse | input | 1 | High in the cycle of frame position 0 |
| mode_fast | input | 1 | 1 = fast mode, 0 = slow mode; sampled at frame start |
| ser_in | input | NS | Serial input lines |
| ser_out | output | NS | Serial output lines |
| ser_oe | output | NS | Per-line output enable for the current slot |
| cm_wr_valid | input | 1 | Connection memory request valid |
| cm_wr_ready | output | 1 | Connection memory request ready (low during a fill) |
| cm_wr_fill | input | 1 | Request is a block fill |
| cm_wr_addr | input | AW | Entry address for a single write |
| cm_wr_data | input | EW | Entry value (11 bits at defaults) |

## Verification
The bench predicts every output bit and enable on every cycle, which catches the following faults:
- A bank rotation that is off by one would show bytes one or three frames late.
- Decoding the slot address with the wrong channels-per-line would garble all of fast mode.
- Putting force-high or message ahead of the enable bit would drive channels that must float.

It also runs directed block fills with a single write queued behind them. A fill that ends early or late, or that lets the queued write through during the fill, shows up either on the ready line or as a wrong entry on the lines. Mode changes at frame boundaries check that no data from the old mode leaks out during the two quiet frames.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic {MODE_SLOW = 1'b0, MODE_FAST = 1'b1} tsi_mode_e;

  // three data banks rotate once per frame
  function automatic logic [1:0] bank_next(input logic [1:0] b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
  import tsi_pkg::*;
#(
  parameter int FRAME = 128,
  localparam int PW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse,
  input  logic          mode_sel,
  output logic [PW-1:0] pos,
  output logic [1:0]    wr_bank,
  output logic [1:0]    rd_bank,
  output logic          fast,
  output logic          live
);
  logic [PW-1:0] pos_q;
  logic [1:0]    bank_q, age_q, age_d;
  tsi_mode_e     mode_q, mode_d;
  logic          started_q, start;

  always_comb begin
    start   = frame_pulse || (started_q && pos_q == '0);
    pos     = frame_pulse ? '0 : pos_q;
    wr_bank = start ? bank_next(bank_q) : bank_q;
    mode_d  = start ? tsi_mode_e'(mode_sel) : mode_q;
    age_d   = age_q;
    if (start) begin
      if (!started_q || mode_d != mode_q) age_d = 2'd0;
      else if (age_q != 2'd2)            age_d = age_q + 2'd1;
    end
  end

  // bank of frame G-2 is the one after the current write bank
  assign rd_bank = bank_next(wr_bank);
  assign fast    = (mode_d == MODE_FAST);
  assign live    = (age_d == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      bank_q    <= '0;
      age_q     <= '0;
      mode_q    <= MODE_SLOW;
      started_q <= 1'b0;
    end else begin
      pos_q     <= (pos == PW'(FRAME - 1)) ? '0 : pos + PW'(1);
      bank_q    <= wr_bank;
      age_q     <= age_d;
      mode_q    <= mode_d;
      started_q <= started_q | start;
    end
  end
endmodule

// File: rtl/tsi_capture.sv
module tsi_capture #(
  parameter int NS    = 4,
  parameter int TOTAL = 32,
  localparam int AW   = $clog2(TOTAL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NS-1:0]          ser_in,
  input  logic                   step,
  input  logic [2:0]             bsel,
  input  logic [NS-1:0]          act,
  input  logic [NS-1:0][AW-1:0]  slot_addr,
  input  logic [1:0]             wr_bank,
  input  logic [1:0]             rd_bank,
  input  logic [NS-1:0][AW-1:0]  rd_addr,
  output logic [NS-1:0][7:0]     rd_data
);
  logic [NS-1:0][6:0] sh_q;
  logic [7:0]         dmem [3][TOTAL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (step)
      for (int s = 0; s < NS; s++) sh_q[s] <= {sh_q[s][5:0], ser_in[s]};
  end

  // byte complete on its eighth sampled bit
  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++)
      if (step && bsel == 3'd7 && act[s])
        dmem[wr_bank][slot_addr[s]] <= {sh_q[s], ser_in[s]};
  end

  always_comb begin
    for (int s = 0; s < NS; s++) rd_data[s] = dmem[rd_bank][rd_addr[s]];
  end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int NS    = 4,
  parameter int TOTAL = 32,
  parameter int FRAME = 128,
  parameter int EW    = 11,
  localparam int AW   = $clog2(TOTAL),
  localparam int FW   = $clog2(FRAME)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic                  wr_fill,
  input  logic [AW-1:0]         wr_addr,
  input  logic [EW-1:0]         wr_data,
  input  logic [NS-1:0][AW-1:0] rd_addr,
  output logic [NS-1:0][EW-1:0] rd_entry
);
  logic [EW-1:0] mem_q [TOTAL];
  logic          busy_q;
  logic [FW-1:0] fcnt_q;
  logic [EW-1:0] fill_val_q;

  assign wr_ready = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      fcnt_q     <= '0;
      fill_val_q <= '0;
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= '0;
    end else if (busy_q) begin
      // one entry per clock, then idle out the rest of the frame
      if (int'(fcnt_q) < TOTAL) mem_q[fcnt_q[AW-1:0]] <= fill_val_q;
      if (fcnt_q == FW'(FRAME - 1)) busy_q <= 1'b0;
      fcnt_q <= fcnt_q + FW'(1);
    end else if (wr_valid) begin
      if (wr_fill) begin
        busy_q     <= 1'b1;
        fcnt_q     <= '0;
        fill_val_q <= wr_data;
      end else begin
        mem_q[wr_addr] <= wr_data;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NS; s++) rd_entry[s] = mem_q[rd_addr[s]];
  end
endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch #(
  parameter int NS    = 4,
  parameter int CHS   = 8,
  localparam int FRAME = 16 * CHS,
  localparam int TOTAL = NS * CHS,
  localparam int AW    = $clog2(TOTAL),
  localparam int PW    = $clog2(FRAME),
  localparam int CW    = PW - 3,
  localparam int SW    = (AW > 8) ? AW : 8,
  localparam int EW    = SW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse,
  input  logic          mode_fast,
  input  logic [NS-1:0] ser_in,
  output logic [NS-1:0] ser_out,
  output logic [NS-1:0] ser_oe,
  input  logic          cm_wr_valid,
  output logic          cm_wr_ready,
  input  logic          cm_wr_fill,
  input  logic [AW-1:0] cm_wr_addr,
  input  logic [EW-1:0] cm_wr_data
);
  logic [PW-1:0] pos, bit_idx;
  logic [1:0]    wr_bank, rd_bank;
  logic          fast, live, step;
  logic [CW-1:0] ch;
  logic [2:0]    bsel;
  logic [NS-1:0]          act;
  logic [NS-1:0][AW-1:0]  slot_addr, src_addr;
  logic [NS-1:0][EW-1:0]  entry;
  logic [NS-1:0][7:0]     rd_data;

  tsi_timing #(.FRAME(FRAME)) u_timing (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .mode_sel(mode_fast),
    .pos(pos), .wr_bank(wr_bank), .rd_bank(rd_bank), .fast(fast), .live(live)
  );

  // slow mode: two clocks per bit, sample on the second
  assign bit_idx = fast ? pos : (pos >> 1);
  assign step    = fast | pos[0];
  assign ch      = bit_idx[PW-1:3];
  assign bsel    = bit_idx[2:0];

  tsi_capture #(.NS(NS), .TOTAL(TOTAL)) u_capture (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .step(step), .bsel(bsel),
    .act(act), .slot_addr(slot_addr), .wr_bank(wr_bank), .rd_bank(rd_bank),
    .rd_addr(src_addr), .rd_data(rd_data)
  );

  tsi_cmem #(.NS(NS), .TOTAL(TOTAL), .FRAME(FRAME), .EW(EW)) u_cmem (
    .clk(clk), .rst_n(rst_n), .wr_valid(cm_wr_valid), .wr_ready(cm_wr_ready),
    .wr_fill(cm_wr_fill), .wr_addr(cm_wr_addr), .wr_data(cm_wr_data),
    .rd_addr(slot_addr), .rd_entry(entry)
  );

  for (genvar s = 0; s < NS; s++) begin : g_line
    logic [7:0] byte_sel;
    logic       ena, bit_v;

    assign act[s]       = (s < NS / 2) ? 1'b1 : !fast;
    assign slot_addr[s] = fast ? AW'(s * 2 * CHS) + AW'(ch) : AW'(s * CHS) + AW'(ch);
    assign src_addr[s]  = entry[s][AW-1:0];
    assign byte_sel     = entry[s][SW] ? entry[s][7:0] : rd_data[s];
    assign bit_v        = byte_sel[3'd7 - bsel];
    // enable outranks force-high, which outranks message
    assign ena          = live && act[s] && entry[s][EW-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ser_oe[s]  <= 1'b0;
        ser_out[s] <= 1'b0;
      end else begin
        ser_oe[s]  <= ena;
        ser_out[s] <= ena && (entry[s][EW-2] || bit_v);
      end
    end
  end
endmodule

// File: rtl/tdm_slot_switch_chk.sv
module tdm_slot_switch_chk #(
  parameter int NS    = 4,
  parameter int FRAME = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_pulse,
  input logic          mode_fast,
  input logic [NS-1:0] ser_out,
  input logic [NS-1:0] ser_oe,
  input logic          cm_wr_valid,
  input logic          cm_wr_ready,
  input logic          cm_wr_fill
);
  localparam logic [NS-1:0] UPPER = {{(NS - NS / 2){1'b1}}, {(NS / 2){1'b0}}};
  localparam int LW = $clog2(FRAME) + 2;

  logic          mode_c, fast_d;
  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_c <= 1'b0;
      fast_d <= 1'b0;
      lowcnt <= '0;
    end else begin
      mode_c <= frame_pulse ? mode_fast : mode_c;
      fast_d <= frame_pulse ? mode_fast : mode_c;
      lowcnt <= cm_wr_ready ? '0 : lowcnt + LW'(1);
    end
  end

  // R4: a floating line is driven low
  a_r4_hiz_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out & ~ser_oe) == '0);

  // R2: upper lines float in fast mode
  a_r2_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fast_d |-> (ser_oe & UPPER) == '0);

  // R8: ready drops only after an accepted fill
  a_r8_fall_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cm_wr_ready) |-> $past(cm_wr_valid && cm_wr_fill));

  // R8: busy window is exactly one frame
  a_r8_one_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cm_wr_ready) |-> lowcnt == LW'(FRAME));
endmodule

bind tdm_slot_switch tdm_slot_switch_chk #(.NS(NS), .FRAME(FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .mode_fast(mode_fast),
  .ser_out(ser_out), .ser_oe(ser_oe), .cm_wr_valid(cm_wr_valid),
  .cm_wr_ready(cm_wr_ready), .cm_wr_fill(cm_wr_fill)
);

// File: tb/tdm_slot_switch_tb.sv
`timescale 1ns/1ps
module tdm_slot_switch_tb;
  localparam int NS = 4, CHS = 8;
  localparam int FRAME = 16 * CHS, TOTAL = NS * CHS;
  localparam int AW = $clog2(TOTAL), EW = 11;
  localparam int NFR = 28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_pulse = 1'b0, mode_fast = 1'b0;
  logic [NS-1:0] ser_in = '0, ser_out, ser_oe;
  logic cm_wr_valid = 1'b0, cm_wr_ready, cm_wr_fill = 1'b0;
  logic [AW-1:0] cm_wr_addr = '0;
  logic [EW-1:0] cm_wr_data = '0;

  always #2.5 clk = ~clk;

  tdm_slot_switch #(.NS(NS), .CHS(CHS)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .mode_fast(mode_fast),
    .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe),
    .cm_wr_valid(cm_wr_valid), .cm_wr_ready(cm_wr_ready), .cm_wr_fill(cm_wr_fill),
    .cm_wr_addr(cm_wr_addr), .cm_wr_data(cm_wr_data)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [EW-1:0] cm_m [TOTAL];
  logic [7:0]    inb [3][TOTAL];
  logic [NS-1:0] exp_oe = '0, exp_out = '0;
  string         exp_tag [NS];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit sched_fast(input int g);
    return (g >= 10 && g < 20);
  endfunction

  function automatic logic [EW-1:0] mk(input bit en, input bit hi, input bit msg,
                                       input logic [7:0] src);
    return {en, hi, msg, src};
  endfunction

  // directed host requests: cycle, fill flag, address, entry
  int dk [8] = '{3, 4, 300, 301, 302, 303, 15 * FRAME + 5, 17 * FRAME};
  bit df [8] = '{1, 0, 0, 0, 0, 0, 1, 1};
  int da [8] = '{0, 2, 0, 5, TOTAL - 1, 1, 0, 0};
  logic [EW-1:0] dd [8];

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit hv = 0, hf = 0, acc = 0, accf = 0, mbusy = 0, fast = 0, live = 0;
    logic [AW-1:0] ha = '0, acca = '0;
    logic [EW-1:0] hd = '0, accd = '0, mval = '0;
    int mcnt = 0, age = 0, di = 0, g = 0, p, bi, ch, b;
    void'($urandom(32'h5A17));
    dd[0] = mk(1, 0, 1, 8'hA5);          // fill: message everywhere
    dd[1] = mk(1, 1, 0, 8'h00);          // R7 queued behind fill, force high
    dd[2] = mk(1, 0, 0, 8'(TOTAL - 1));  // multicast of last source
    dd[3] = dd[2];
    dd[4] = dd[2];
    dd[5] = mk(1, 0, 0, 8'h00);
    dd[6] = mk(0, 1, 1, 8'hFF);          // R4 enable off outranks others
    dd[7] = mk(1, 0, 0, 8'h03);          // fill: all switched from source 3
    for (int i = 0; i < TOTAL; i++) cm_m[i] = '0;
    for (int s = 0; s < NS; s++) exp_tag[s] = "R10";

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check(ser_oe == '0 && ser_out == '0, "R10", "lines after reset", {ser_oe, ser_out}, 0);
      check(cm_wr_ready == 1'b1, "R10", "ready after reset", cm_wr_ready, 1);
    end

    for (int k = 0; k < NFR * FRAME; k++) begin
      @(negedge clk);
      // compare pins with the prediction for the previous cycle
      for (int s = 0; s < NS; s++)
        check(ser_oe[s] == exp_oe[s] && ser_out[s] == exp_out[s], exp_tag[s],
              $sformatf("line %0d cycle %0d oe,out", s, k),
              {ser_oe[s], ser_out[s]}, {exp_oe[s], exp_out[s]});
      // connection memory model (R7, R8)
      if (mbusy) begin
        if (mcnt < TOTAL) cm_m[mcnt] = mval;
        mcnt++;
        if (mcnt == FRAME) mbusy = 0;
      end
      if (acc) begin
        if (accf) begin mbusy = 1; mcnt = 0; mval = accd; end
        else cm_m[acca] = accd;
        acc = 0;
      end
      check(cm_wr_ready == !mbusy, "R8", $sformatf("ready cycle %0d", k), cm_wr_ready, !mbusy);

      // line stimulus (R1, R9)
      p = k % FRAME;
      if (p == 0) begin
        g = k / FRAME;
        if (g == 0) age = 0;
        else if (sched_fast(g) != sched_fast(g - 1)) age = 0;
        else if (age < 2) age++;
        fast = sched_fast(g);
        live = (age == 2);
        for (int i = 0; i < TOTAL; i++) inb[g % 3][i] = 8'($urandom);
      end
      frame_pulse = (p == 0);
      mode_fast   = fast;
      bi = fast ? p : p / 2;
      ch = bi / 8;
      b  = bi % 8;
      for (int s = 0; s < NS; s++) begin
        if (!fast || s < NS / 2)
          ser_in[s] = inb[g % 3][fast ? s * 2 * CHS + ch : s * CHS + ch][7 - b];
        else
          ser_in[s] = 1'($urandom);      // R2 ignored input
      end

      // host requests
      if (!hv) begin
        if (di < 8 && k >= dk[di]) begin
          hv = 1; hf = df[di]; ha = AW'(da[di]); hd = dd[di]; di++;
        end else if (k >= 3 * FRAME && $urandom % 10 == 0) begin
          hv = 1; hf = 0; ha = AW'($urandom);
          hd = mk($urandom % 4 != 0, $urandom % 8 == 0, $urandom % 4 == 0, 8'($urandom));
        end
      end
      cm_wr_valid = hv; cm_wr_fill = hf; cm_wr_addr = ha; cm_wr_data = hd;
      if (hv && cm_wr_ready) begin
        acc = 1; accf = hf; acca = ha; accd = hd; hv = 0;
      end

      // prediction for this cycle (R1..R6, R9)
      for (int s = 0; s < NS; s++) begin
        logic [EW-1:0] e;
        logic [7:0] byt;
        e = cm_m[fast ? s * 2 * CHS + ch : s * CHS + ch];
        exp_oe[s] = 0; exp_out[s] = 0;
        if (!live) exp_tag[s] = "R9";
        else if (fast && s >= NS / 2) exp_tag[s] = "R2";
        else if (!e[10]) exp_tag[s] = "R4";
        else begin
          exp_oe[s] = 1;
          if (e[9]) begin exp_tag[s] = "R5"; exp_out[s] = 1; end
          else begin
            if (e[8]) begin exp_tag[s] = "R6"; byt = e[7:0]; end
            else begin exp_tag[s] = "R3 R1"; byt = inb[(g + 1) % 3][e[AW-1:0]]; end
            exp_out[s] = byt[7 - b];
          end
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule